// File: doc/BRIEF.md
# Misaligned Operand Bus Cycle Sequencer

This block sits between a load/store unit and a 32-bit big-endian data bus. It accepts one request at a time to read or write a byte, word (16-bit) or long-word (32-bit) operand at any byte address. It then issues as many aligned bus cycles as the operand needs and never lets a single cycle straddle a long-word boundary. Each cycle presents a byte address, a size code for that piece alone, and write data already moved onto the byte lanes the piece occupies.

The sequencer waits for the slave's acknowledge on every cycle before it moves on. On reads it gathers the returned lanes into a right-justified register image. A one-cycle completion pulse marks the moment that image is final. The requester keeps its operand in register form and never deals with lane positions or boundary splits.

Top module: `mts_sequencer`

## Requirements
- R1: After reset `busy`, `bus_valid` and `done` are low and `rd_data` is zero.
- R2: A request is taken only when `req_valid` is high while `busy` is low. A request presented while busy does not disturb the running sequence. A request with size code 11 is dropped and starts no bus cycle. `bus_write` follows the accepted request's direction.
- R3: Size codes are 01 byte, 10 word and 00 long word, on both `req_size` and `bus_size`. A byte operand, a word at offset 0 or 2, and a long word at offset 0 each finish in one cycle at the operand's own size.
- R4: A long word at offset 1 runs as byte@1, word@2, then byte@0 of the next long word. At offset 2 it runs as word@2 then word@0 of the next long word. At offset 3 it runs as byte@3, word@0 of the next long word, then byte@2 of that long word.
- R5: A word at offset 3 runs as byte@3 then byte@0 of the next long word. A word at offset 1 is a single word cycle on lanes 23:8.
- R6: `bus_addr` is the byte address of the first operand byte the cycle carries. A piece in the following long word therefore sits at the request's long-word address plus 4, with the new offset in bits 1:0.
- R7: On writes, the byte at offset o travels on `bus_wdata[31-8o -: 8]`. The operand's most significant byte goes to the lowest address, so a long word's bits 31:24 and a word's bits 15:8 go first. Lanes outside the current piece are driven to zero.
- R8: On reads, `rd_data` holds the operand right-justified when `done` is high. A word fills bits 15:0 and a byte fills bits 7:0, with zeros above. Lanes outside each piece are ignored.
- R9: Once `bus_valid` is high, address, size, direction and write data stay unchanged until the clock edge where `bus_ack` is high. The next piece is presented in the very next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the final acknowledge. `busy` falls in that same cycle. `rd_data` then holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | 32 | Operand byte address |
| req_wdata | input | 32 | Right-justified write operand |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Right-justified read result |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | 32 | Byte address of the piece |
| bus_size | output | 2 | Size code of the piece |
| bus_wdata | output | 32 | Lane-positioned write data |
| bus_ack | input | 1 | Slave acknowledge |
| bus_rdata | input | 32 | Lane-positioned read data |

## Verification
The bench walks every size and offset pairing in both directions and mixes in random addresses. These include addresses just below the top of the address space, where the next-long-word step wraps. Some designs would issue a word at offset 3 or a greedy word at offset 1 inside a long word. Others would give up a piece early or compute the carry address wrongly. Such designs show a wrong size or address in the piece sequence. Designs that miscount lanes or reverse byte order show up as misplaced write bytes or a scrambled `rd_data`. The slave drives random garbage on idle lanes, so a read path that does not ignore those lanes leaves bytes above the operand that are not zero. Random acknowledge delays and requests injected while busy expose a design that lets the bus change before the acknowledge or restarts mid-sequence.

// File: rtl/mts_pkg.sv
`timescale 1ns/1ps
package mts_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int OFF_W  = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES) + 1;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  function automatic logic [CNT_W-1:0] size_bytes(xfer_size_e s);
    case (s)
      SZ_BYTE: size_bytes = CNT_W'(1);
      SZ_WORD: size_bytes = CNT_W'(2);
      SZ_LONG: size_bytes = CNT_W'(LANES);
      default: size_bytes = '0;
    endcase
  endfunction
endpackage

// File: rtl/mts_piece_plan.sv
`timescale 1ns/1ps
// Picks the next aligned piece from the current byte offset and the
// number of operand bytes still to move.
module mts_piece_plan
  import mts_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] left,
  output xfer_size_e       pc_size,
  output logic [CNT_W-1:0] pc_bytes
);
  logic full_long;
  logic word_fits;

  // whole long word only from lane 0
  assign full_long = (left == CNT_W'(LANES)) && (off == '0);
  // word from an even lane, or a lone 2-byte operand that starts on lane 1
  assign word_fits = (left >= CNT_W'(2)) &&
                     ((off[0] == 1'b0) ||
                      ((left == CNT_W'(2)) && (off == OFF_W'(1))));

  always_comb begin
    if (full_long)      pc_size = SZ_LONG;
    else if (word_fits) pc_size = SZ_WORD;
    else                pc_size = SZ_BYTE;
  end

  assign pc_bytes = size_bytes(pc_size);
endmodule

// File: rtl/mts_lane_steer.sv
`timescale 1ns/1ps
// Maps operand bytes to big-endian bus lanes for one piece, both ways.
// Lane L of the piece holds register byte (left + off - 1 - L).
module mts_lane_steer
  import mts_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  left,
  input  logic [CNT_W-1:0]  pc_bytes,
  input  logic [DATA_W-1:0] wop,
  input  logic [DATA_W-1:0] rlanes,
  input  logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] wlanes,
  output logic [DATA_W-1:0] acc_next
);
  localparam int SUM_W = CNT_W + 1;

  logic [LANES-1:0] act;
  logic [OFF_W-1:0] rb [LANES];
  logic [SUM_W-1:0] lo;
  logic [SUM_W-1:0] hi;

  assign lo = SUM_W'(off);
  assign hi = SUM_W'(off) + SUM_W'(pc_bytes);

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    assign act[L] = (SUM_W'(L) >= lo) && (SUM_W'(L) < hi);
    assign rb[L]  = OFF_W'(left) + off - OFF_W'(1) - OFF_W'(L);
    assign wlanes[(LANES-1-L)*LANE_W +: LANE_W] =
      act[L] ? wop[rb[L]*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    acc_next = acc;
    for (int L = 0; L < LANES; L++) begin
      if (act[L]) acc_next[rb[L]*LANE_W +: LANE_W] = rlanes[(LANES-1-L)*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/mts_sequencer.sv
`timescale 1ns/1ps
module mts_sequencer
  import mts_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wop_q, wop_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              done_q;

  xfer_size_e        rq_size;
  xfer_size_e        pc_size;
  logic [CNT_W-1:0]  pc_bytes;
  logic [DATA_W-1:0] acc_merged;
  logic              accept;
  logic              step;
  logic              last;
  logic              dp_en;

  assign rq_size = xfer_size_e'(req_size);

  mts_piece_plan u_plan (
    .off      (addr_q[OFF_W-1:0]),
    .left     (left_q),
    .pc_size  (pc_size),
    .pc_bytes (pc_bytes)
  );

  mts_lane_steer u_steer (
    .off      (addr_q[OFF_W-1:0]),
    .left     (left_q),
    .pc_bytes (pc_bytes),
    .wop      (wop_q),
    .rlanes   (bus_rdata),
    .acc      (acc_q),
    .wlanes   (bus_wdata),
    .acc_next (acc_merged)
  );

  assign accept = (st_q == ST_IDLE) && req_valid && (rq_size != SZ_RSVD);
  assign step   = (st_q == ST_RUN) && bus_ack;
  assign last   = (left_q == pc_bytes);
  assign dp_en  = accept || step;

  // next state
  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    left_d = left_q;
    wr_d   = wr_q;
    wop_d  = wop_q;
    acc_d  = acc_q;
    if (accept) begin
      st_d   = ST_RUN;
      addr_d = req_addr;
      left_d = size_bytes(rq_size);
      wr_d   = req_write;
      wop_d  = req_wdata;
      acc_d  = '0;
    end else if (step) begin
      addr_d = addr_q + ADDR_W'(pc_bytes);
      left_d = left_q - pc_bytes;
      if (!wr_q) acc_d = acc_merged;
      if (last) st_d = ST_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= step && last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      wr_q   <= 1'b0;
      wop_q  <= '0;
      acc_q  <= '0;
    end else if (dp_en) begin
      addr_q <= addr_d;
      left_q <= left_d;
      wr_q   <= wr_d;
      wop_q  <= wop_d;
      acc_q  <= acc_d;
    end
  end

  assign busy      = (st_q == ST_RUN);
  assign bus_valid = (st_q == ST_RUN);
  assign bus_write = wr_q;
  assign bus_addr  = addr_q;
  assign bus_size  = pc_size;
  assign done      = done_q;
  assign rd_data   = acc_q;

  // R9: bus cycle held until acknowledged
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_size) &&
                                 $stable(bus_wdata) && $stable(bus_write)));
  // R3: a long-word piece only from lane 0
  a_r3_long_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size == SZ_LONG) |-> (bus_addr[OFF_W-1:0] == '0));
  // R5: a word piece never starts on the last lane
  a_r5_word_in_long: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size == SZ_WORD) |-> (bus_addr[OFF_W-1:0] != OFF_W'(LANES-1)));
  // R2: reserved code never reaches the bus
  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size != SZ_RSVD));
  // R10: completion is a single-cycle pulse after an acknowledge
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_valid && bus_ack) && !busy));
endmodule

// File: tb/tb_mts_sequencer.sv
`timescale 1ns/1ps
module tb_mts_sequencer;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        busy;
  logic        done;
  logic [31:0] rd_data;
  logic        bus_valid;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_ack;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mts_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [1:0] code_of(input int nbytes);
    return (nbytes == 1) ? 2'b01 : (nbytes == 2) ? 2'b10 : 2'b00;
  endfunction

  // expected pieces: offset from request long-word address, and byte count
  task automatic plan_exp(input int nb, input int off, output int np,
                          output int rel[3], output int psz[3]);
    rel = '{0, 0, 0};
    psz = '{0, 0, 0};
    if (nb == 1) begin np = 1; rel[0] = off; psz[0] = 1; end
    else if (nb == 2) begin
      if (off == 3) begin np = 2; rel = '{3, 4, 0}; psz = '{1, 1, 0}; end
      else begin np = 1; rel[0] = off; psz[0] = 2; end
    end else begin
      case (off)
        0: begin np = 1; rel[0] = 0; psz[0] = 4; end
        1: begin np = 3; rel = '{1, 2, 4}; psz = '{1, 2, 1}; end
        2: begin np = 2; rel = '{2, 4, 0}; psz = '{2, 2, 0}; end
        default: begin np = 3; rel = '{3, 4, 6}; psz = '{1, 2, 1}; end
      endcase
    end
  endtask

  task automatic run_op(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input bit intrude);
    int nb, np, off;
    int rel[3];
    int psz[3];
    string tag;
    logic [31:0] exp_rd;
    nb  = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
    off = int'(addr[1:0]);
    plan_exp(nb, off, np, rel, psz);
    if (nb == 4 && off != 0) tag = "R4";
    else if (nb == 2 && off[0]) tag = "R5";
    else tag = "R3";
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_addr = $urandom; req_wdata = $urandom;
    chk(busy == 1'b1, "R2 accept", {31'd0, busy}, 32'd1);
    for (int i = 0; i < np; i++) begin
      logic [31:0] pa, ew;
      int w;
      pa = {addr[31:2], 2'b00} + 32'(rel[i]);
      w = int'($urandom % 3);
      if (intrude && i == 0 && w == 0) w = 1;
      for (int j = 0; j < w; j++) begin
        chk(bus_valid && bus_addr == pa, "R9 hold", bus_addr, pa);
        if (intrude && i == 0 && j == 0) begin
          req_valid = 1'b1; req_write = ~wr; req_size = 2'b00; req_addr = 32'h0000_0100;
        end
        @(negedge clk);
        req_valid = 1'b0;
      end
      chk(bus_valid == 1'b1, "R9 valid", {31'd0, bus_valid}, 32'd1);
      chk(bus_addr == pa, "R6 addr", bus_addr, pa);
      chk(bus_size == code_of(psz[i]), tag, {30'd0, bus_size}, {30'd0, code_of(psz[i])});
      chk(bus_write == wr, "R2 dir", {31'd0, bus_write}, {31'd0, wr});
      ew = '0;
      for (int L = 0; L < 4; L++) begin
        if (L >= int'(pa[1:0]) && L < int'(pa[1:0]) + psz[i]) begin
          int k;
          k = int'(pa - addr) + L - int'(pa[1:0]);
          ew[(3-L)*8 +: 8] = wd[(nb-1-k)*8 +: 8];
        end
      end
      if (wr) chk(bus_wdata == ew, "R7 lanes", bus_wdata, ew);
      bus_ack = 1'b1;
      for (int L = 0; L < 4; L++) begin
        if (L >= int'(pa[1:0]) && L < int'(pa[1:0]) + psz[i])
          bus_rdata[(3-L)*8 +: 8] = mem_byte({pa[31:2], 2'(L)});
        else
          bus_rdata[(3-L)*8 +: 8] = 8'($urandom);
      end
      @(negedge clk);
      bus_ack = 1'b0; bus_rdata = $urandom;
    end
    exp_rd = '0;
    for (int k = 0; k < nb; k++) exp_rd[(nb-1-k)*8 +: 8] = mem_byte(addr + 32'(k));
    chk(done == 1'b1, "R10 done", {31'd0, done}, 32'd1);
    chk(busy == 1'b0, "R10 busy", {31'd0, busy}, 32'd0);
    if (!wr) chk(rd_data == exp_rd, "R8 rdata", rd_data, exp_rd);
    @(negedge clk);
    chk(done == 1'b0, "R10 pulse", {31'd0, done}, 32'd0);
    chk(bus_valid == 1'b0, "R10 idle", {31'd0, bus_valid}, 32'd0);
    if (!wr) chk(rd_data == exp_rd, "R10 hold", rd_data, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
    req_addr = '0; req_wdata = '0; bus_ack = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && bus_valid == 1'b0, "R1 idle", {30'd0, busy, bus_valid}, 32'd0);
    chk(done == 1'b0, "R1 done", {31'd0, done}, 32'd0);
    chk(rd_data == 32'd0, "R1 rdata", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reserved size code is dropped
    req_valid = 1'b1; req_size = 2'b11; req_addr = 32'h40; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && bus_valid == 1'b0, "R2 reserved", {30'd0, busy, bus_valid}, 32'd0);
    // directed sweep: R3 R4 R5 over every size and offset
    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 4; o++) begin
        logic [1:0] sc;
        sc = (s == 0) ? 2'b01 : (s == 1) ? 2'b10 : 2'b00;
        run_op(1'b0, sc, 32'h1000_0010 + 32'(o), 32'h0, 1'b0);
        run_op(1'b1, sc, 32'h2000_0020 + 32'(o), 32'hA1B2_C3D4, 1'b0);
      end
    end
    // address wrap at the top of the space (R6)
    run_op(1'b0, 2'b00, 32'hFFFF_FFFD, 32'h0, 1'b0);
    run_op(1'b1, 2'b10, 32'hFFFF_FFFF, 32'h0000_5A3C, 1'b0);
    // R2: request while busy is ignored
    run_op(1'b0, 2'b00, 32'h0000_3001, 32'h0, 1'b1);
    run_op(1'b1, 2'b00, 32'h0000_3003, 32'h1122_3344, 1'b1);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sc;
      int pick;
      pick = int'($urandom % 3);
      sc = (pick == 0) ? 2'b01 : (pick == 1) ? 2'b10 : 2'b00;
      run_op(1'($urandom), sc, $urandom, $urandom, (($urandom % 8) == 0));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule